// File: doc/BRIEF.md
# LAPS Transmit Framer

This block turns a packet arriving as a byte stream into a LAPS frame on a continuous outbound byte stream. Each frame starts with a 0x7E flag. Four header bytes follow: an address byte, a control byte and a two-byte protocol identifier, all taken from configuration inputs. After the header come the payload, a 32-bit frame check sequence and a closing 0x7E flag.

Octet transparency applies to every byte between the flags. A data byte equal to 0x7E or 0x7D is sent as a two-byte escape pair. The payload can optionally pass through a self-synchronizing x^43+1 scrambler first. When no packet is waiting, the output carries 0x7E fill.

Both edges use a valid/ready handshake. The upstream source is held off while the second byte of an escape pair goes out. The outbound stream stalls only when the payload source runs dry in the middle of a frame. Configuration inputs are expected to be stable while a frame is in flight.

Top module: `laps_tx_framer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `out_valid` is 1, `out_data` is 0x7E and `in_ready` is 0.
- R2: A frame is sent in this order: flag 0x7E, `cfg_addr`, `cfg_ctrl`, `cfg_sapi[15:8]`, `cfg_sapi[7:0]`, the payload bytes in arrival order (the byte with `in_last`=1 ends the payload), four FCS bytes, flag 0x7E.
- R3: Any header, payload or FCS byte equal to 0x7E is sent as 0x7D followed by 0x5E.
- R4: Any header, payload or FCS byte equal to 0x7D is sent as 0x7D followed by 0x5D. No other byte is altered by escaping.
- R5: The FCS is CRC-32 with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and a final complement. It is computed over the unescaped header and payload bytes as placed in the frame (after scrambling) and sent least significant byte first.
- R6: With `cfg_scram_en`=1, each payload bit (MSB first within a byte) is XORed with the scrambler output bit produced 43 bits earlier. The history is cleared only by reset, continues across frames and advances only on scrambled payload bytes. With `cfg_scram_en`=0, payload passes unchanged. Header and FCS are never scrambled.
- R7: A payload byte is accepted only in a cycle with `in_valid` and `in_ready` both 1. `in_ready` is 0 outside the payload phase and while the second byte of an escape pair is being sent.
- R8: A byte is transferred only with `out_valid` and `out_ready` both 1. While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with `out_data` unchanged. `out_valid` drops only while the payload phase waits for input.
- R9: The closing flag of one frame and the opening flag of the next are separate, so consecutive frames are separated by at least two 0x7E bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Header address byte |
| cfg_ctrl | input | 8 | Header control byte |
| cfg_sapi | input | 16 | Two-byte protocol identifier, high byte sent first |
| cfg_scram_en | input | 1 | Enables the x^43+1 payload scrambler |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_last | input | 1 | Payload byte is the last one of the packet |
| in_ready | output | 1 | Framer accepts the payload byte this cycle |
| out_data | output | 8 | Outbound byte |
| out_valid | output | 1 | Outbound byte is valid |
| out_ready | input | 1 | Downstream accepts the outbound byte |

## Verification
The bench drives headers made of 0x7E and 0x7D bytes, payloads that are runs of both values, and a payload containing every byte value. It does this with the scrambler on and off, under random backpressure and with input gaps.

A design that escapes only payload bytes would send a raw 0x7E inside the header and break the frame into two. Seeding or reflecting the CRC wrongly, or running it over escaped bytes, shows up as a wrong tail on every frame. Restarting the scrambler at each frame, or advancing it while disabled, corrupts the payloads of later frames.

Keeping `in_ready` high during the second escape byte would take a byte that the output cannot carry. Sharing one flag between back-to-back frames would leave too few separators.

// File: rtl/laps_tx_pkg.sv
package laps_tx_pkg;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ESC_BYTE   = 8'h7D;
    localparam logic [7:0]  ESC_FLIP   = 8'h20;
    localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
    localparam int          HDR_BYTES  = 4;
    localparam int          FCS_BYTES  = 4;
    localparam int          IDX_W      = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_FCS,
        ST_CLOSE
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [31:0]      crc;
    } seq_regs_t;

    typedef struct packed {
        logic       pend;
        logic [7:0] second;
    } esc_regs_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'h0, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/laps_tx_scrambler.sv
module laps_tx_scrambler #(
    parameter int TAP = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       adv_i,
    input  logic [7:0] data_i,
    output logic [7:0] data_o
);

    logic [TAP-1:0] hist_d, hist_q;
    logic [TAP-1:0] walk;
    logic [7:0]     scr;

    always_comb begin
        walk = hist_q;
        scr  = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            scr[i] = data_i[i] ^ walk[TAP-1];
            walk   = {walk[TAP-2:0], scr[i]};
        end
        hist_d = (adv_i && en_i) ? walk : hist_q;
        data_o = en_i ? scr : data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/laps_tx_seq.sv
module laps_tx_seq
    import laps_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_addr_i,
    input  logic [7:0]  cfg_ctrl_i,
    input  logic [15:0] cfg_sapi_i,
    input  logic [7:0]  pay_i,
    input  logic        in_valid_i,
    input  logic        in_last_i,
    input  logic        take_i,
    output logic [7:0]  raw_byte_o,
    output logic        raw_flag_o,
    output logic        raw_valid_o,
    output logic        pay_phase_o,
    output logic        idle_o
);

    seq_regs_t r_d, r_q;
    logic [8*HDR_BYTES-1:0] hdr_word;
    logic [8*FCS_BYTES-1:0] fcs_word;

    assign hdr_word = {cfg_sapi_i[7:0], cfg_sapi_i[15:8], cfg_ctrl_i, cfg_addr_i};
    assign fcs_word = ~r_q.crc;

    always_comb begin
        r_d         = r_q;
        raw_byte_o  = FLAG_BYTE;
        raw_flag_o  = 1'b0;
        raw_valid_o = 1'b1;
        pay_phase_o = 1'b0;
        idle_o      = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                raw_flag_o = 1'b1;
                idle_o     = 1'b1;
                if (take_i && in_valid_i) begin
                    r_d.st  = ST_HDR;
                    r_d.idx = '0;
                    r_d.crc = CRC_SEED;
                end
            end
            ST_HDR: begin
                raw_byte_o = hdr_word[{r_q.idx, 3'b000} +: 8];
                if (take_i) begin
                    r_d.crc = crc32_step(r_q.crc, raw_byte_o);
                    if (r_q.idx == IDX_W'(HDR_BYTES - 1)) begin
                        r_d.st  = ST_PAY;
                        r_d.idx = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                pay_phase_o = 1'b1;
                raw_byte_o  = pay_i;
                raw_valid_o = in_valid_i;
                if (take_i) begin
                    r_d.crc = crc32_step(r_q.crc, pay_i);
                    if (in_last_i) begin
                        r_d.st  = ST_FCS;
                        r_d.idx = '0;
                    end
                end
            end
            ST_FCS: begin
                raw_byte_o = fcs_word[{r_q.idx, 3'b000} +: 8];
                if (take_i) begin
                    if (r_q.idx == IDX_W'(FCS_BYTES - 1)) begin
                        r_d.st = ST_CLOSE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_CLOSE: begin
                raw_flag_o = 1'b1;
                if (take_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.idx <= '0;
            r_q.crc <= CRC_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    AST_HDR_THEN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HDR && r_q.idx == IDX_W'(HDR_BYTES - 1) && take_i) |=> (r_q.st == ST_PAY)) // R2
        else $error("header did not hand over to payload");

    AST_CLOSE_AFTER_FCS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLOSE) |-> (raw_flag_o && raw_valid_o)) // R2
        else $error("closing flag missing");

endmodule

// File: rtl/laps_tx_escape.sv
module laps_tx_escape
    import laps_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] raw_byte_i,
    input  logic       raw_flag_i,
    input  logic       raw_valid_i,
    input  logic       out_ready_i,
    output logic [7:0] out_data_o,
    output logic       out_valid_o,
    output logic       take_o,
    output logic       busy_o
);

    esc_regs_t e_d, e_q;
    logic      need_esc;

    assign need_esc = !raw_flag_i && (raw_byte_i == FLAG_BYTE || raw_byte_i == ESC_BYTE);
    assign busy_o   = e_q.pend;

    always_comb begin
        e_d         = e_q;
        take_o      = 1'b0;
        if (e_q.pend) begin
            out_data_o  = e_q.second;
            out_valid_o = 1'b1;
            if (out_ready_i) begin
                e_d.pend = 1'b0;
            end
        end else begin
            out_data_o  = need_esc ? ESC_BYTE : raw_byte_i;
            out_valid_o = raw_valid_i;
            take_o      = raw_valid_i && out_ready_i;
            if (take_o && need_esc) begin
                e_d.pend   = 1'b1;
                e_d.second = raw_byte_i ^ ESC_FLIP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q.pend   <= 1'b0;
            e_q.second <= 8'h00;
        end else begin
            e_q <= e_d;
        end
    end

    AST_LEAD_BEFORE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_q.pend) |-> ($past(out_data_o) == ESC_BYTE)) // R3
        else $error("escape pair without lead byte");

    AST_SECOND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.pend |-> (out_data_o == 8'h5E || out_data_o == 8'h5D)) // R4
        else $error("bad second byte of escape pair");

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))) // R8
        else $error("outbound byte changed under backpressure");

endmodule

// File: rtl/laps_tx_framer.sv
module laps_tx_framer
    import laps_tx_pkg::*;
#(
    parameter int SCR_TAP = 43
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_ctrl,
    input  logic [15:0] cfg_sapi,
    input  logic        cfg_scram_en,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready
);

    logic [7:0] pay_byte;
    logic [7:0] raw_byte;
    logic       raw_flag;
    logic       raw_valid;
    logic       pay_phase;
    logic       seq_idle;
    logic       take;
    logic       esc_busy;
    logic       pay_take;

    assign pay_take = pay_phase && take;
    assign in_ready = pay_phase && out_ready && !esc_busy;

    laps_tx_scrambler #(
        .TAP (SCR_TAP)
    ) scr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (cfg_scram_en),
        .adv_i  (pay_take),
        .data_i (in_data),
        .data_o (pay_byte)
    );

    laps_tx_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_addr_i  (cfg_addr),
        .cfg_ctrl_i  (cfg_ctrl),
        .cfg_sapi_i  (cfg_sapi),
        .pay_i       (pay_byte),
        .in_valid_i  (in_valid),
        .in_last_i   (in_last),
        .take_i      (take),
        .raw_byte_o  (raw_byte),
        .raw_flag_o  (raw_flag),
        .raw_valid_o (raw_valid),
        .pay_phase_o (pay_phase),
        .idle_o      (seq_idle)
    );

    laps_tx_escape esc_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_byte_i  (raw_byte),
        .raw_flag_i  (raw_flag),
        .raw_valid_i (raw_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data),
        .out_valid_o (out_valid),
        .take_o      (take),
        .busy_o      (esc_busy)
    );

    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !esc_busy) |-> (out_valid && out_data == FLAG_BYTE && !in_ready)) // R1
        else $error("idle output is not fill");

    AST_ACCEPT_MOVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready)) // R7
        else $error("payload accepted without an outbound transfer");

    AST_STALL_ONLY_IN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (pay_phase && !in_valid)) // R8
        else $error("outbound stream stalled outside payload wait");

endmodule

// File: tb/laps_tx_framer_tb.sv
module laps_tx_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'hFF;
    logic [7:0]  cfg_ctrl = 8'h03;
    logic [15:0] cfg_sapi = 16'h0001;
    logic        cfg_scram_en = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;

    always #4 clk = ~clk;

    laps_tx_framer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_addr     (cfg_addr),
        .cfg_ctrl     (cfg_ctrl),
        .cfg_sapi     (cfg_sapi),
        .cfg_scram_en (cfg_scram_en),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_ready     (in_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .out_ready    (out_ready)
    );

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int gap_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] glfsr = 16'h1D2B;

    byte unsigned pl_q[$];
    byte unsigned exp_b[$];
    int           exp_len[$];
    string        exp_tag[$];
    byte unsigned obs_b[$];
    int           obs_len[$];
    bit           scr_hist[$];

    int  r7_bad = 0, r8_bad = 0, r9_bad = 0, r7_seen = 0;
    bit  in_frame = 0, second_due = 0, prev_stall = 0;
    int  cur_len = 0, flag_run = 0, frames_started = 0;
    logic [7:0] prev_data = 8'h00;
    bit  done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc(input byte unsigned d[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (d[k]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ d[k][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return ~c;
    endfunction

    function automatic byte unsigned model_scr(input byte unsigned d);
        byte unsigned o = 0;
        for (int i = 7; i >= 0; i--) begin
            bit t = (scr_hist.size() >= 43) ? scr_hist[scr_hist.size() - 43] : 1'b0;
            bit ob = d[i] ^ t;
            o[i] = ob;
            scr_hist.push_back(ob);
        end
        return o;
    endfunction

    task automatic push_escaped(input byte unsigned v);
        if (v == 8'h7E || v == 8'h7D) begin
            exp_b.push_back(8'h7D);
            exp_b.push_back(v ^ 8'h20);
        end else begin
            exp_b.push_back(v);
        end
    endtask

    task automatic send_pkt(input string tag);
        byte unsigned raw[$];
        logic [31:0] f;
        int start;
        raw.push_back(cfg_addr);
        raw.push_back(cfg_ctrl);
        raw.push_back(cfg_sapi[15:8]);
        raw.push_back(cfg_sapi[7:0]);
        foreach (pl_q[k]) raw.push_back(cfg_scram_en ? model_scr(pl_q[k]) : pl_q[k]);
        f = model_crc(raw);
        for (int k = 0; k < 4; k++) raw.push_back(f[8*k +: 8]);
        start = exp_b.size();
        foreach (raw[k]) push_escaped(raw[k]);
        exp_len.push_back(exp_b.size() - start);
        exp_tag.push_back(tag);
        foreach (pl_q[k]) begin
            bit acc;
            if (gap_mode != 0) begin
                glfsr = {glfsr[14:0], glfsr[15] ^ glfsr[13] ^ glfsr[12] ^ glfsr[10]};
                if (glfsr[0] && glfsr[2]) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
            end
            in_data  = pl_q[k];
            in_last  = (k == pl_q.size() - 1);
            in_valid = 1'b1;
            forever begin
                #2;
                acc = in_ready;
                @(negedge clk);
                if (acc) break;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        repeat (120) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = lfsr[0] | lfsr[3];
                default: out_ready = lfsr[0];
            endcase
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (prev_stall) begin
                    if (!(out_valid && out_data == prev_data)) r8_bad++;
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = out_data;
                if (out_valid && out_ready) begin
                    if (out_data == 8'h7E) begin
                        if (in_ready) r7_bad++;
                        if (in_frame) begin
                            obs_len.push_back(cur_len);
                            in_frame = 0;
                            flag_run = 1;
                        end else begin
                            flag_run++;
                        end
                        second_due = 0;
                    end else begin
                        if (!in_frame) begin
                            if (frames_started > 0 && flag_run < 2) r9_bad++;
                            frames_started++;
                            in_frame = 1;
                            cur_len = 0;
                        end
                        obs_b.push_back(out_data);
                        cur_len++;
                        if (second_due) begin
                            r7_seen++;
                            if (in_ready) r7_bad++;
                            second_due = 0;
                        end else if (out_data == 8'h7D) begin
                            second_due = 1;
                        end
                    end
                end
            end
        end
    end

    task automatic finish_up();
        int pos = 0;
        check(obs_len.size() == exp_len.size(), "R2", "frame count",
              obs_len.size(), exp_len.size());
        for (int f = 0; f < exp_len.size() && f < obs_len.size(); f++) begin
            bit ok = (obs_len[f] == exp_len[f]);
            int bad_a = obs_len[f], bad_e = exp_len[f];
            if (ok) begin
                for (int k = 0; k < exp_len[f]; k++) begin
                    if (obs_b[pos + k] != exp_b[pos + k]) begin
                        ok = 0;
                        bad_a = obs_b[pos + k];
                        bad_e = exp_b[pos + k];
                        break;
                    end
                end
            end
            check(ok, exp_tag[f], $sformatf("frame %0d content", f), bad_a, bad_e);
            pos += exp_len[f];
        end
        check(r7_bad == 0, "R7", "in_ready high on flag or escape second byte", r7_bad, 0);
        check(r7_seen > 0, "R7", "escape pairs observed", r7_seen, 1);
        check(r8_bad == 0, "R8", "output changed under backpressure", r8_bad, 0);
        check(r9_bad == 0, "R9", "frames separated by fewer than two flags", r9_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "R8", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #2;
        check(out_valid == 1'b1, "R1", "reset out_valid", out_valid, 1);
        check(out_data == 8'h7E, "R1", "reset out_data", out_data, 8'h7E);
        check(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        check(out_valid && out_data == 8'h7E && !in_ready, "R1", "idle fill",
              out_data, 8'h7E);
        @(negedge clk);

        // R2 R5: lengths 1..8, flag and escape values at chosen positions
        for (int len = 1; len <= 8; len++) begin
            pl_q.delete();
            for (int i = 0; i < len; i++) begin
                if (i % 3 == 1)      pl_q.push_back(8'h7E);
                else if (i % 5 == 2) pl_q.push_back(8'h7D);
                else                 pl_q.push_back(byte'((len * 13 + i * 29) & 8'hFF));
            end
            send_pkt("R2 R5");
        end
        drain();

        // R3 R4: escape values in header, runs in payload, backpressure and gaps
        cfg_addr = 8'h7E; cfg_ctrl = 8'h7D; cfg_sapi = 16'h7D7E;
        rdy_mode = 2; gap_mode = 1;
        pl_q.delete();
        pl_q.push_back(8'h7E); pl_q.push_back(8'h7E); pl_q.push_back(8'h7D);
        pl_q.push_back(8'h7D); pl_q.push_back(8'h7E); pl_q.push_back(8'h5E);
        send_pkt("R3 R4 R7 R8");
        pl_q.delete();
        pl_q.push_back(8'h7D);
        send_pkt("R3 R4 R9");
        drain();

        // R6: scrambler on, history spans frames
        cfg_addr = 8'hFF; cfg_ctrl = 8'h03; cfg_sapi = 16'h0001;
        cfg_scram_en = 1'b1; rdy_mode = 1;
        for (int n = 0; n < 3; n++) begin
            pl_q.delete();
            for (int i = 0; i < 20 + 30 * n; i++) pl_q.push_back(byte'((i * 7 + n) & 8'hFF));
            send_pkt("R6");
        end
        drain();

        // R3 R4 R5: every byte value, scrambler off
        cfg_scram_en = 1'b0; rdy_mode = 0; gap_mode = 0;
        pl_q.delete();
        for (int i = 0; i < 256; i++) pl_q.push_back(byte'(i));
        send_pkt("R3 R4 R5");
        drain();

        // R6: every byte value scrambled, history resumes after a plain frame
        cfg_scram_en = 1'b1; rdy_mode = 2; gap_mode = 1;
        send_pkt("R6 R8");
        drain();
        #2;
        check(out_valid && out_data == 8'h7E && !in_ready, "R1", "fill after traffic",
              out_data, 8'h7E);
        @(negedge clk);
        done = 1;
        finish_up();
    end

endmodule